// File: doc/BRIEF.md
# MDIO Management Register Controller

This block gives a host a small register window for reaching the management registers of an external Ethernet PHY over a two-wire serial management link (MDC clock, bidirectional MDIO data). The host writes one 32-bit command word that packs the PHY address, the PHY register number, a read/write opcode and, for a write, the 16-bit data. Writing that word launches a serial frame. The host then polls a busy flag, and for reads also a read-valid flag. When the read completes, the PHY's 16-bit reply sits in the low half of the same command word.

A second host register keeps the 5-bit address of the attached PHY for software to store and read back. The serial clock is the system clock divided by the parameter `MDC_DIV`. Each frame is 64 MDC periods long. The block drives MDIO on MDC falling edges and samples it on rising edges. During a read it releases the data pin for the turnaround and the reply.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After synchronous reset, the command readback and the PHY-address readback are all zeros, MDC is low and the MDIO output enable is low.
- R2: The command readback has this layout: bit 28 busy, bit 27 read-valid, bit 26 opcode (1 = read, 0 = write), bits 25:21 register number, bits 20:16 PHY address, bits 15:0 data, and zeros in bits 31:29. The opcode and the address fields show the last command that was accepted.
- R3: A write to the command word (`reg_sel` = 0) while busy is clear is accepted. Busy reads 1 from the next cycle on and stays 1 for exactly 64 × `MDC_DIV` cycles.
- R4: A write to the command word while busy is set is ignored. Every field of the readback keeps its value.
- R5: The MDIO bit sequence, MSB first with one bit per MDC period, is: 32 ones, start `01`, opcode `10` for a read or `01` for a write, the 5-bit PHY address, the 5-bit register number, the turnaround, then 16 data bits. Fields can take any value from 0 to 31.
- R6: MDC is low while idle. While busy it is a square wave with period `MDC_DIV` system clocks that starts low. MDIO output changes only on MDC falling edges.
- R7: A read samples MDIO on the 16 MDC rising edges of the data phase, MSB first. At completion, bits 15:0 hold the sampled value and read-valid becomes 1 in the same cycle that busy clears.
- R8: During a read, the MDIO output enable is low for the two turnaround bits and the 16 data bits. A write drives every bit, with turnaround `10` and its data field. The enable is low while idle.
- R9: Read-valid clears in the cycle after a new command is accepted. A write command leaves it at 0 when it completes.
- R10: A write with `reg_sel` = 1 stores `reg_wdata[4:0]` as the PHY address, whether or not busy is set. Bits 31:5 of its readback stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe, one cycle |
| reg_sel | input | 1 | 0 selects the command word, 1 selects the PHY-address register |
| reg_wdata | input | 32 | Host write data |
| cmd_rdata | output | 32 | Command word readback with busy and read-valid flags |
| pa_rdata | output | 32 | PHY-address register readback |
| mdc | output | 1 | Management serial clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (low = released) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench aims at the frame boundaries.

- **First bit and last bit.** An off-by-one bit counter would shift every field by an MDC period or leave busy up one period too long.
- **Turnaround.** A design that released the pin one bit late would collide with the PHY's turnaround zero. One that sampled the turnaround would return its reply shifted by one bit.
- **Field extremes.** It uses PHY address and register 31 and 0, and read replies 0xFFFF and 0x0000, which expose a field that is truncated or swapped.
- **Register traffic.** It issues a command while busy, which must not disturb the active transaction. It writes the PHY-address register with all upper bits set, and it launches a command in the very cycle that busy falls.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int BUSY_BIT   = 28;
    localparam int RVAL_BIT   = 27;
    localparam int OP_BIT     = 26;

    typedef struct packed {
        logic        rd;
        logic [4:0]  reg_n;
        logic [4:0]  phy;
        logic [15:0] data;
    } mdio_cmd_t;

    function automatic mdio_cmd_t unpack_cmd(input logic [31:0] w);
        mdio_cmd_t c;
        c.rd    = w[OP_BIT];
        c.reg_n = w[25:21];
        c.phy   = w[20:16];
        c.data  = w[15:0];
        return c;
    endfunction

    // Serial frame, bit 63 leaves first.
    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0]  op_bits;
        logic [1:0]  ta_bits;
        logic [15:0] tail;
        op_bits = c.rd ? 2'b10 : 2'b01;
        ta_bits = c.rd ? 2'b11 : 2'b10;
        tail    = c.rd ? 16'hFFFF : c.data;
        return {32'hFFFF_FFFF, 2'b01, op_bits, c.phy, c.reg_n, ta_bits, tail};
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int MDC_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HALF = MDC_DIV / 2;
    localparam int CW   = $clog2(HALF) + 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = (cnt == CW'(HALF - 1));
    assign rise_stb = run && wrap && !mdc;
    assign fall_stb = run && wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam int BW = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] frame_q;
    logic [BW-1:0]         bitn;
    logic                  is_rd;
    logic [15:0]           shin;

    assign done    = busy && fall_stb && (bitn == '0);
    assign rd_data = shin;
    assign mdio_oe = busy && !(is_rd && (bitn <= BW'(17)));
    assign mdio_o  = busy ? frame_q[bitn] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            bitn    <= '0;
            frame_q <= '0;
            is_rd   <= 1'b0;
            shin    <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            bitn    <= BW'(FRAME_BITS - 1);
            frame_q <= build_frame(cmd);
            is_rd   <= cmd.rd;
        end else if (busy) begin
            if (rise_stb && is_rd && (bitn <= BW'(15)))
                shin <= {shin[14:0], mdio_i};
            if (fall_stb) begin
                if (bitn == '0) busy <= 1'b0;
                else            bitn <= bitn - 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int MDC_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] cmd_rdata,
    output logic [31:0] pa_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t   cmd_q;
    mdio_cmd_t   cmd_in;
    logic        rvalid_q;
    logic [4:0]  pa_q;
    logic        busy, done, accept, rise_stb, fall_stb;
    logic [15:0] rd_data;

    assign cmd_in = unpack_cmd(reg_wdata);
    assign accept = reg_wr && !reg_sel && !busy;

    mdio_clkdiv #(.MDC_DIV(MDC_DIV)) u_div (
        .clk(clk), .rst(rst), .run(busy),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_engine u_eng (
        .clk(clk), .rst(rst), .start(accept), .cmd(cmd_in),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
        .busy(busy), .done(done), .rd_data(rd_data),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            rvalid_q <= 1'b0;
            pa_q     <= '0;
        end else begin
            if (accept) begin
                cmd_q    <= cmd_in;
                rvalid_q <= 1'b0;
            end else if (done && cmd_q.rd) begin
                cmd_q.data <= rd_data;
                rvalid_q   <= 1'b1;
            end
            if (reg_wr && reg_sel)
                pa_q <= reg_wdata[4:0];
        end
    end

    assign cmd_rdata = {3'b000, busy, rvalid_q, cmd_q.rd, cmd_q.reg_n, cmd_q.phy, cmd_q.data};
    assign pa_rdata  = {27'd0, pa_q};
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic        reg_sel,
    input logic [31:0] cmd_rdata,
    input logic [31:0] pa_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    logic busy, rval, acc;
    assign busy = cmd_rdata[28];
    assign rval = cmd_rdata[27];
    assign acc  = reg_wr && !reg_sel && !busy;

    a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        acc |=> busy);

    a_r4_ignore_when_busy: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_sel && busy) |=> $stable(cmd_rdata[26:16]));

    a_r6_mdc_low_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    a_r6_mdio_on_fall: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

    a_r7_rvalid_at_end: assert property (@(posedge clk) disable iff (rst)
        $rose(rval) |-> (!busy && $past(busy)));

    a_r8_release_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    a_r9_rvalid_clear: assert property (@(posedge clk) disable iff (rst)
        acc |=> !rval);

    a_r10_pa_upper_zero: assert property (@(posedge clk) disable iff (rst)
        pa_rdata[31:5] == 27'd0);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .cmd_rdata(cmd_rdata), .pa_rdata(pa_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_mgmt_ctrl.sv
module sim_mdio_mgmt_ctrl;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] cmd_rdata, pa_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    mdio_mgmt_ctrl #(.MDC_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata), .pa_rdata(pa_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Behavioural reference state
    logic        m_busy, m_rd, m_rv;
    logic [4:0]  m_reg, m_phy, m_pa;
    logic [15:0] m_data;
    logic [63:0] m_frame;
    int          m_k;
    logic [15:0] phy_word = 16'h0000;

    function automatic logic [63:0] mk_frame(input logic rd, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] d);
        logic [63:0] f;
        f = '1;
        f[31:30] = 2'b01;
        f[29:28] = rd ? 2'b10 : 2'b01;
        f[27:23] = phy;
        f[22:18] = rg;
        f[17:16] = 2'b10;
        f[15:0]  = d;
        return f;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        logic acc;
        cyc++;
        if (rst) begin
            m_busy = 0; m_rd = 0; m_rv = 0; m_reg = 0; m_phy = 0;
            m_data = 0; m_pa = 0; m_k = 0; m_frame = '1;
        end else begin
            acc = reg_wr && !reg_sel && !m_busy;
            if (m_busy) begin
                if (m_k == 64*DIV - 1) begin
                    m_busy = 0;
                    if (m_rd) begin m_data = phy_word; m_rv = 1; end
                end else m_k++;
            end
            if (acc) begin
                m_rd = reg_wdata[26]; m_reg = reg_wdata[25:21];
                m_phy = reg_wdata[20:16]; m_data = reg_wdata[15:0];
                m_rv = 0; m_busy = 1; m_k = 0;
                m_frame = mk_frame(m_rd, m_phy, m_reg, m_data);
            end
            if (reg_wr && reg_sel) m_pa = reg_wdata[4:0];
        end
    end

    // Per-cycle comparison and PHY model, away from the active edge
    always @(negedge clk) begin
        int j;
        j = m_k / DIV;
        if (!rst) begin
            chk("R2/R3/R4/R7/R9 cmd_rdata", cmd_rdata,
                {3'b000, m_busy, m_rv, m_rd, m_reg, m_phy, m_data});
            chk("R10 pa_rdata", pa_rdata, {27'd0, m_pa});
            chk("R6 mdc", {31'd0, mdc}, {31'd0, m_busy && ((m_k / HALF) % 2 == 1)});
            chk("R8 mdio_oe", {31'd0, mdio_oe}, {31'd0, m_busy && !(m_rd && j >= 46)});
            if (m_busy && mdio_oe)
                chk("R5 mdio_o", {31'd0, mdio_o}, {31'd0, m_frame[63-j]});
        end
        if (m_busy && m_rd)
            mdio_i <= (j >= 48) ? phy_word[63-j] : (j == 47 ? 1'b0 : 1'b1);
        else
            mdio_i <= 1'b1;
    end

    task automatic send_cmd(input logic rd, input logic [4:0] phy,
                            input logic [4:0] rg, input logic [15:0] d);
        reg_wr = 1; reg_sel = 0;
        reg_wdata = {5'd0, rd, rg, phy, d};
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic write_pa(input logic [31:0] v);
        reg_wr = 1; reg_sel = 1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    endtask

    task automatic wait_idle();
        while (cmd_rdata[28]) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        logic [31:0] snap;
        rst = 1; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd_rdata reset", cmd_rdata, 32'd0);
        chk("R1 pa_rdata reset", pa_rdata, 32'd0);
        chk("R1 mdc/oe reset", {30'd0, mdc, mdio_oe}, 32'd0);

        // R5 R8 write frame
        send_cmd(1'b0, 5'd5, 5'd3, 16'h1234);
        chk("R3 busy after accept", {31'd0, cmd_rdata[28]}, 32'd1);
        wait_idle();
        chk("R9 write leaves rvalid low", {31'd0, cmd_rdata[27]}, 32'd0);

        // R7 read with mixed pattern
        phy_word = 16'hA5C3;
        send_cmd(1'b1, 5'd1, 5'd2, 16'h0000);
        wait_idle();
        chk("R7 read data", {16'd0, cmd_rdata[15:0]}, 32'h0000_A5C3);
        chk("R7 rvalid set", {31'd0, cmd_rdata[27]}, 32'd1);

        // R9 rvalid clears on next accepted command; R10 PA write while busy
        send_cmd(1'b0, 5'd31, 5'd0, 16'hFFFF);
        chk("R9 rvalid cleared", {31'd0, cmd_rdata[27]}, 32'd0);
        repeat (20) @(negedge clk);
        write_pa(32'hFFFF_FFE5);
        chk("R10 pa upper bits held zero", pa_rdata, 32'h0000_0005);
        // R4 command ignored while busy
        snap = cmd_rdata;
        send_cmd(1'b1, 5'd9, 5'd9, 16'h5555);
        chk("R4 fields unchanged", {21'd0, cmd_rdata[26:16]}, {21'd0, snap[26:16]});
        wait_idle();

        // R5 field extremes, back-to-back launch in the cycle busy falls
        phy_word = 16'hFFFF;
        send_cmd(1'b1, 5'd31, 5'd31, 16'h0000);
        wait_idle();
        chk("R7 all-ones reply", {16'd0, cmd_rdata[15:0]}, 32'h0000_FFFF);
        phy_word = 16'h0000;
        send_cmd(1'b1, 5'd0, 5'd0, 16'hABCD);
        wait_idle();
        chk("R7 all-zero reply", {16'd0, cmd_rdata[15:0]}, 32'h0000_0000);
        chk("R2 layout after read", cmd_rdata & 32'hFC00_0000, 32'h0C00_0000);

        repeat (5) @(negedge clk);
        chk("R6 idle mdc low", {31'd0, mdc}, 32'd0);
        summary();
    end
endmodule